// File: doc/BRIEF.md
# Interrupt-Acknowledge Bus Cycle Generator

This block runs the master side of one interrupt-acknowledge read on a 32-bit external bus. A requester offers a 3-bit interrupt level. The offer is taken when the block is idle and holds bus ownership. The block then drives a fixed acknowledge address with the level in bits 4:2. It also drives read direction, a byte size code, the acknowledge transfer type, and a transfer modifier equal to the level. It pulses the transfer-start strobe for one clock and then waits for the slave's transfer acknowledge.

When the acknowledge arrives, the block takes the vector byte from the top data lane, D[31:24]. On the following cycle it presents that byte with a one-clock done pulse and releases the bus. An optional watchdog limit ends a cycle that gets no acknowledge: the block raises a one-clock error pulse and returns to idle.

The request side is a valid/ready handshake. A request waits, with level held, until `req_ready` is high on a clock edge. `req_ready` is high only while the block is idle and `bus_grant` is high. The result side has no back-pressure: `done` and `tmo_err` are single-cycle pulses that the consumer must take when they appear.

Top module: `iack_cycle_gen`

## Requirements
- R1: While `rst_n` is low, the block is idle. `bus_oe`, `ts`, `done`, `tmo_err`, `vec`, `addr`, `rw`, `siz`, `tt` and `tm` are all zero, and `req_ready` equals `bus_grant`.
- R2: `req_ready` is high exactly when the block is idle and `bus_grant` is high. A `req_valid` seen on an edge without `req_ready` has no effect on any output.
- R3: During an active cycle, `addr[31:5]` is all ones, `addr[4:2]` is the accepted level and `addr[1:0]` is 0, and the value stays stable until the cycle ends.
- R4: During an active cycle, `rw` is 1 (read), `siz` is 2'b01 (byte), `tt` is 2'b11 (acknowledge) and `tm` equals the accepted level.
- R5: `ts` is high for exactly the first clock after a request is accepted and low on every other clock.
- R6: `ta` is sampled only in clocks after the `ts` clock. A `ta` during the `ts` clock is ignored.
- R7: `ta` sampled high ends the cycle. On the next clock, `done` is high for one clock and `vec` shows `rd_data[31:24]` from the `ta` clock. `vec` holds that value until the next `done`.
- R8: `bus_oe` is high from the `ts` clock through the clock in which `ta` or the timeout is sampled. Whenever `bus_oe` is low, `addr`, `rw`, `siz`, `tt` and `tm` are zero.
- R9: With `tmo_limit` = L > 0, if `ta` is low in L consecutive clocks after `ts`, then on the next clock `tmo_err` is high for one clock, the block is idle, `done` stays low and `vec` is unchanged. With L = 0 the block waits without limit.
- R10: A `ta` in the L-th waiting clock completes the cycle normally, with no `tmo_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Acknowledge request offered |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_level | input | 3 | Interrupt level to acknowledge |
| bus_grant | input | 1 | Bus ownership granted to this master |
| tmo_limit | input | 16 | Waiting clocks before timeout, 0 disables |
| ta | input | 1 | Transfer acknowledge from slave |
| rd_data | input | 32 | Read data bus |
| bus_oe | output | 1 | Address and control outputs are driven |
| addr | output | 32 | Address bus |
| rw | output | 1 | 1 means read |
| siz | output | 2 | Transfer size code |
| tt | output | 2 | Transfer type code |
| tm | output | 3 | Transfer modifier code |
| ts | output | 1 | Transfer-start strobe |
| done | output | 1 | One-clock completion pulse |
| vec | output | 8 | Captured vector byte |
| tmo_err | output | 1 | One-clock timeout pulse |

## Verification
The bench holds `req_valid` high during a busy cycle and with the grant removed. A design that leaks these offers would start a second strobe or change the address mid-cycle. It drives `ta` during the strobe clock, so a design that samples it too early would finish one clock ahead and capture the wrong byte. The timeout is exercised with no acknowledge, with an acknowledge exactly on the last allowed clock, and with the limit disabled. An off-by-one counter would either fire on the winning acknowledge or fire one clock late. Garbage on the data lane outside the acknowledge clock exposes a vector register that does not hold its value.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } iack_state_t;

  localparam logic [1:0] SIZ_BYTE = 2'b01;
  localparam logic [1:0] TT_IACK  = 2'b11;
  localparam int         VEC_W    = 8;
endpackage

// File: rtl/iack_fsm.sv
module iack_fsm
  import iack_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LVL_W-1:0] level_in,
  input  logic             ta,
  input  logic             expire,
  output iack_state_t      state,
  output logic [LVL_W-1:0] level
);
  iack_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (accept) nxt = ST_START;
      ST_START: nxt = ST_WAIT;
      ST_WAIT:  if (ta || expire) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      level <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && accept) level <= level_in;
    end
  end

  // R5
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_START |=> state == ST_WAIT);

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_IDLE |=> $stable(level));
endmodule

// File: rtl/iack_timer.sv
module iack_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            waiting,
  input  logic            ta,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] cnt;
  logic [TO_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign expire   = waiting && !ta && (limit != '0) && (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (waiting) cnt <= cnt_next[TO_W-1:0];
    else              cnt <= '0;
  end

  // R10
  ta_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |-> !expire);
endmodule

// File: rtl/iack_capture.sv
module iack_capture
  import iack_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             waiting,
  input  logic             ta,
  input  logic             expire,
  input  logic [DATA_W-1:0] rd_data,
  output logic             done,
  output logic             tmo_err,
  output logic [VEC_W-1:0] vec
);
  localparam int LANE_LO = DATA_W - VEC_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      tmo_err <= 1'b0;
      vec     <= '0;
    end else begin
      done    <= waiting && ta;
      tmo_err <= expire;
      if (waiting && ta) vec <= rd_data[DATA_W-1:LANE_LO];
    end
  end

  // R7
  done_after_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ta));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> !done && !$past(ta));

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(vec));
endmodule

// File: rtl/iack_cycle_gen.sv
module iack_cycle_gen
  import iack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 3,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LVL_W-1:0]  req_level,
  input  logic              bus_grant,
  input  logic [TO_W-1:0]   tmo_limit,
  input  logic              ta,
  input  logic [DATA_W-1:0] rd_data,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic [1:0]        siz,
  output logic [1:0]        tt,
  output logic [LVL_W-1:0]  tm,
  output logic              ts,
  output logic              done,
  output logic [VEC_W-1:0]  vec,
  output logic              tmo_err
);
  localparam int ONES_W = ADDR_W - LVL_W - 2;

  iack_state_t      state;
  logic [LVL_W-1:0] level;
  logic             accept;
  logic             waiting;
  logic             expire;

  assign req_ready = (state == ST_IDLE) && bus_grant;
  assign accept    = req_valid && req_ready;
  assign waiting   = (state == ST_WAIT);

  iack_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .level_in(req_level),
    .ta(ta), .expire(expire), .state(state), .level(level)
  );

  iack_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .ta(ta),
    .limit(tmo_limit), .expire(expire)
  );

  iack_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .ta(ta), .expire(expire),
    .rd_data(rd_data), .done(done), .tmo_err(tmo_err), .vec(vec)
  );

  always_comb begin
    bus_oe = (state != ST_IDLE);
    ts     = (state == ST_START);
    addr   = '0;
    rw     = 1'b0;
    siz    = '0;
    tt     = '0;
    tm     = '0;
    if (bus_oe) begin
      addr = {{ONES_W{1'b1}}, level, 2'b00};
      rw   = 1'b1;
      siz  = SIZ_BYTE;
      tt   = TT_IACK;
      tm   = level;
    end
  end

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> ts);

  // R5
  ts_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts |=> !ts && bus_oe);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && !ts |-> $stable(addr));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done || tmo_err |-> !bus_oe);
endmodule

// File: tb/sim_iack_cycle_gen.sv
module sim_iack_cycle_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_level = '0;
  logic        bus_grant = 1'b0;
  logic [15:0] tmo_limit = '0;
  logic        ta = 1'b0;
  logic [31:0] rd_data = '0;
  logic        bus_oe;
  logic [31:0] addr;
  logic        rw;
  logic [1:0]  siz;
  logic [1:0]  tt;
  logic [2:0]  tm;
  logic        ts;
  logic        done;
  logic [7:0]  vec;
  logic        tmo_err;

  int total = 0;
  int bad = 0;
  string ctx = "reset";

  // reference model state
  int          m_st = 0;   // 0 idle, 1 strobe, 2 waiting
  int          m_wcnt = 0;
  logic [2:0]  m_lvl = '0;
  logic        m_done = 1'b0;
  logic        m_err = 1'b0;
  logic [7:0]  m_vec = '0;

  always #10 clk = ~clk;

  iack_cycle_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .bus_grant(bus_grant), .tmo_limit(tmo_limit),
    .ta(ta), .rd_data(rd_data), .bus_oe(bus_oe), .addr(addr), .rw(rw),
    .siz(siz), .tt(tt), .tm(tm), .ts(ts), .done(done), .vec(vec),
    .tmo_err(tmo_err)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_wcnt = 0; m_lvl = '0; m_done = 0; m_err = 0; m_vec = '0;
    end else begin
      m_done = 0;
      m_err  = 0;
      if (m_st == 0) begin
        if (req_valid && bus_grant) begin m_st = 1; m_lvl = req_level; end
      end else if (m_st == 1) begin
        m_st = 2; m_wcnt = 0;
      end else begin
        if (ta) begin
          m_st = 0; m_done = 1; m_vec = rd_data[31:24];
        end else begin
          m_wcnt++;
          if (tmo_limit != 0 && m_wcnt >= tmo_limit) begin m_st = 0; m_err = 1; end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, ctx, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic act_on;
    act_on = (m_st != 0);
    chk("R2 req_ready", 32'(req_ready), 32'((m_st == 0) && bus_grant));
    chk("R5 ts", 32'(ts), 32'(m_st == 1));
    chk("R8 bus_oe", 32'(bus_oe), 32'(act_on));
    chk("R3 addr", addr, act_on ? {27'h7FFFFFF, m_lvl, 2'b00} : 32'h0);
    chk("R4 rw", 32'(rw), 32'(act_on));
    chk("R4 siz", 32'(siz), act_on ? 32'h1 : 32'h0);
    chk("R4 tt", 32'(tt), act_on ? 32'h3 : 32'h0);
    chk("R4 tm", 32'(tm), act_on ? 32'(m_lvl) : 32'h0);
    chk("R7 done", 32'(done), 32'(m_done));
    chk("R7 vec", 32'(vec), 32'(m_vec));
    chk("R9 tmo_err", 32'(tmo_err), 32'(m_err));
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // one acknowledge cycle: wait_n idle-TA clocks, then TA unless no_ta
  task automatic run_iack(input logic [2:0] lvl, input int wait_n, input logic [7:0] v,
                          input bit early_ta, input bit no_ta, input bit hold_req);
    req_valid = 1'b1;
    req_level = lvl;
    do step(); while (!ts);
    if (!hold_req) req_valid = 1'b0;
    req_level = ~lvl;
    ta = early_ta;                 // R6: ignored during strobe clock
    rd_data = early_ta ? {~v, 24'h0} : 32'hDEAD_BEEF;
    for (int i = 0; i < wait_n; i++) begin
      step();
      ta = 1'b0;
      rd_data = 32'h5A5A_0000 + 32'(i);
    end
    if (!no_ta) begin
      step();
      ta = 1'b1;
      rd_data = {v, 24'h13_57_9B};
    end
    step();
    ta = 1'b0;
    req_valid = 1'b0;
    rd_data = 32'hFFFF_FFFF;
    step();
  endtask

  initial begin
    repeat (3) step();
    ctx = "R1 reset";
    req_valid = 1'b1; bus_grant = 1'b1;
    step();
    req_valid = 1'b0;
    rst_n = 1'b1;
    step();

    ctx = "R2 no grant";
    bus_grant = 1'b0; req_valid = 1'b1; req_level = 3'd4;
    repeat (4) step();
    req_valid = 1'b0;
    bus_grant = 1'b1;
    step();

    ctx = "R7 basic";
    run_iack(3'd5, 3, 8'hA5, 0, 0, 0);
    ctx = "R6 early ta";
    run_iack(3'd1, 2, 8'h3C, 1, 0, 0);
    ctx = "R2 busy hold";
    run_iack(3'd7, 4, 8'hC3, 0, 0, 1);
    ctx = "R7 zero wait";
    run_iack(3'd0, 0, 8'h81, 0, 0, 0);

    ctx = "R9 timeout";
    tmo_limit = 16'd4;
    run_iack(3'd2, 4, 8'h00, 0, 1, 0);
    repeat (2) step();
    ctx = "R10 ta on last";
    tmo_limit = 16'd3;
    run_iack(3'd6, 2, 8'h7E, 0, 0, 0);
    ctx = "R9 limit one";
    tmo_limit = 16'd1;
    run_iack(3'd3, 1, 8'h00, 0, 1, 0);
    ctx = "R9 disabled";
    tmo_limit = 16'd0;
    run_iack(3'd4, 20, 8'h42, 0, 0, 0);
    repeat (3) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired t=%0t actual=hung expected=finished", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule